// File: doc/BRIEF.md
# Flash embedded operation controller

This block is a synthesizable model of the control logic inside a byte-wide NOR-style flash device. A host drives bus cycles with active-low chip enable, write enable and output enable. Write cycles feed a command decoder that recognises an unlock prefix followed by a command byte. The decoder starts byte programs and sector erases, and it takes single-write suspend and resume commands. A small register-file array stands in for the cells. Erased bytes read 0xFF, and a program can only clear bits.

While an operation runs, the ready output is low. A read returns a status byte in place of array data. Bit 7 is a data-polling flag and bit 6 flips on every read. An erase first walks the sector and preprograms every byte that is not already 0x00. It then waits out an erase interval, and a final sweep sets every byte to 0xFF. An erase can be held in a suspended state. In that state the host may read or program other sectors, and it can later resume the erase. Per-sector protect inputs block operations on a sector. A low-supply input blocks all writes, and the asynchronous hardware reset aborts everything.

Operation states: `OP_READ` (array read mode), `OP_PROG` (program countdown), `OP_PREP` (preprogram walk), `OP_ERASE` (erase interval), `OP_CLEAR` (set-to-0xFF sweep), `OP_SUSP` (erase suspended), `OP_SPROG` (program while suspended).

Transitions:
- `OP_READ`→`OP_PROG` on an accepted program.
- `OP_READ`→`OP_PREP` on an accepted erase.
- `OP_PROG`→`OP_READ` and `OP_SPROG`→`OP_SUSP` when the program count ends.
- `OP_PREP`→`OP_ERASE` after the last byte.
- `OP_ERASE`→`OP_CLEAR` when the interval ends.
- `OP_CLEAR`→`OP_READ` after the last byte.
- `OP_PREP`/`OP_ERASE`/`OP_CLEAR`→`OP_SUSP` on suspend.
- `OP_SUSP`→saved phase on resume.
- `OP_SUSP`→`OP_SPROG` on a program accepted in another sector.

Decoder states: `CD_IDLE`, `CD_U1`, `CD_U2`, `CD_PDATA`, `CD_E80`, `CD_EU1`, `CD_EU2`. The decoder advances one state per matching write and falls back to `CD_IDLE` on any mismatch.

Top module: `flash_op_ctrl`

## Requirements
- R1: After the hardware reset (rst_n low), ready is 1 and reads return array bytes. A reset during an operation aborts it, so ready is 1 one cycle after release and the target byte keeps its old value. The array powers up all 0xFF.
- R2: The program sequence is four writes: 0xAA to 0x555, 0x55 to 0x2AA, 0xA0 to 0x555, then the data to the target address. After it, ready is low for exactly PROG_CYC cycles starting the cycle after the data write. The stored byte becomes old AND data, because bits only go from 1 to 0.
- R3: While a program runs, a read at any address returns bit 7 equal to the inverse of bit 7 of the data being written. After it finishes, the read returns the stored byte.
- R4: While any operation runs (ready low), a read returns a status byte with bits 5:0 equal to zero. Bit 6 takes the opposite value on each successive read.
- R5: The erase sequence is six writes: 0xAA to 0x555, 0x55 to 0x2AA, 0x80 to 0x555, 0xAA to 0x555, 0x55 to 0x2AA, then 0x30 to any address in the sector, where the sector number is addr[10:6]. Status reads during the erase show bit 7 = 0. At the end every byte of that sector reads 0xFF and other sectors are unchanged.
- R6: The busy time of an erase is PREP_CYC cycles for each byte that is not 0x00, plus 1 cycle for each byte already 0x00, plus ERASE_CYC, plus one cycle per byte of the sector. With the defaults this is 360 cycles for a fully erased sector.
- R7: A single write of 0xB0 to any address during an erase suspends it, and ready is 1 the cycle after. Reads of other sectors then return array data. Reads of the erasing sector return bit 7 = 1 and bit 6 holding still. The erase progress is frozen while suspended.
- R8: While suspended, a program to another sector runs normally and then returns to the suspended state with ready 1. A program aimed at the erasing sector is ignored.
- R9: A single write of 0x30 while suspended resumes the erase, and ready is low the cycle after. The erase then completes with the sector reading 0xFF.
- R10: A program or erase aimed at a sector whose sect_prot bit is 1 is ignored: ready stays 1 and the contents are unchanged.
- R11: While vlow is 1, every host write is ignored, so a full command sequence starts nothing.
- R12: A write that breaks a command sequence returns the decoder to idle. The rest of that broken sequence starts nothing, and a fresh full sequence then works.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low; a write is taken on its falling edge |
| oe_n | input | 1 | Output enable, active low; a read is taken on its falling edge |
| addr | input | ADDR_W (11) | Byte address |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Read data or status byte, registered |
| ready | output | 1 | 1 when no program or erase is running |
| vlow | input | 1 | Low-supply indication; blocks writes |
| sect_prot | input | 2**SECT_W (32) | Per-sector protect flags |

## Verification
A write strobe is taken at the first clock edge that sees we_n low. The operation state changes at that same edge, so ready is due at the sample point half a cycle later. The bench reads ready there, directly after the last write of each sequence. Read data is registered at the edge that sees oe_n low, and the bench samples rdata at the following falling clock edge. Busy lengths are counted as the number of falling edges with ready low, starting at the falling edge right after the final command write. That count equals PROG_CYC for a program and the R6 formula for an erase. No reads are interleaved with the busy intervals whose length is measured, so the measured lengths match those formulas exactly.

// File: rtl/flash_pkg.sv
`timescale 1ns/1ps
package flash_pkg;

    typedef enum logic [2:0] {
        OP_READ,
        OP_PROG,
        OP_PREP,
        OP_ERASE,
        OP_CLEAR,
        OP_SUSP,
        OP_SPROG
    } op_state_e;

    typedef enum logic [2:0] {
        CD_IDLE,
        CD_U1,
        CD_U2,
        CD_PDATA,
        CD_E80,
        CD_EU1,
        CD_EU2
    } cd_state_e;

    localparam logic [10:0] UNLOCK_ADDR_A = 11'h555;
    localparam logic [10:0] UNLOCK_ADDR_B = 11'h2AA;
    localparam logic [7:0]  KEY_A         = 8'hAA;
    localparam logic [7:0]  KEY_B         = 8'h55;
    localparam logic [7:0]  CODE_PROG     = 8'hA0;
    localparam logic [7:0]  CODE_ERASE1   = 8'h80;
    localparam logic [7:0]  CODE_ERASE2   = 8'h30;
    localparam logic [7:0]  CODE_SUSP     = 8'hB0;
    localparam logic [7:0]  CODE_RESUME   = 8'h30;

    function automatic logic [7:0] status_byte(input logic poll, input logic toggle);
        return {poll, toggle, 6'b000000};
    endfunction

endpackage

// File: rtl/flash_bus_sync.sv
`timescale 1ns/1ps
module flash_bus_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic we_n,
    input  logic oe_n,
    input  logic vlow,
    output logic wr_evt,
    output logic rd_evt
);
    logic we_q;
    logic oe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_q <= 1'b1;
            oe_q <= 1'b1;
        end else begin
            we_q <= we_n;
            oe_q <= oe_n;
        end
    end

    // one event per strobe: the first edge that sees the enable low
    assign wr_evt = !ce_n && !we_n && oe_n && we_q && !vlow;
    assign rd_evt = !ce_n && !oe_n && we_n && oe_q;

endmodule

// File: rtl/flash_cmd_decode.sv
`timescale 1ns/1ps
module flash_cmd_decode
    import flash_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_evt,
    input  logic              cmd_en,
    input  logic              susp_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        data,
    output logic              go_prog,
    output logic              go_erase,
    output logic              go_susp,
    output logic              go_resume
);
    cd_state_e cs, cs_n;
    logic at_a, at_b;

    assign at_a = (addr == ADDR_W'(UNLOCK_ADDR_A));
    assign at_b = (addr == ADDR_W'(UNLOCK_ADDR_B));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cs <= CD_IDLE;
        else        cs <= cs_n;
    end

    always_comb begin
        cs_n      = cs;
        go_prog   = 1'b0;
        go_erase  = 1'b0;
        go_susp   = 1'b0;
        go_resume = 1'b0;
        if (!cmd_en) begin
            cs_n    = CD_IDLE;
            go_susp = wr_evt && susp_en && (data == CODE_SUSP);
        end else if (wr_evt) begin
            cs_n = CD_IDLE;
            unique case (cs)
                CD_IDLE: begin
                    if (at_a && data == KEY_A) cs_n = CD_U1;
                    else go_resume = (data == CODE_RESUME);
                end
                CD_U1:    if (at_b && data == KEY_B) cs_n = CD_U2;
                CD_U2: begin
                    if (at_a && data == CODE_PROG)        cs_n = CD_PDATA;
                    else if (at_a && data == CODE_ERASE1) cs_n = CD_E80;
                end
                CD_PDATA: go_prog = 1'b1;
                CD_E80:   if (at_a && data == KEY_A) cs_n = CD_EU1;
                CD_EU1:   if (at_b && data == KEY_B) cs_n = CD_EU2;
                CD_EU2:   go_erase = (data == CODE_ERASE2);
                default:  cs_n = CD_IDLE;
            endcase
        end
    end

    AST_ONE_GO: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({go_prog, go_erase, go_susp, go_resume})); // R12

    AST_PROG_AFTER_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
        go_prog |-> (cs == CD_PDATA && wr_evt)); // R2

endmodule

// File: rtl/flash_cell_array.sv
`timescale 1ns/1ps
module flash_cell_array #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] host_addr,
    output logic [7:0]        host_q,
    input  logic [ADDR_W-1:0] op_addr,
    output logic [7:0]        op_q,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] cells [DEPTH];

    initial begin
        for (int i = 0; i < DEPTH; i++) cells[i] = 8'hFF;
    end

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign host_q = cells[host_addr];
    assign op_q   = cells[op_addr];

endmodule

// File: rtl/flash_op_ctrl.sv
`timescale 1ns/1ps
module flash_op_ctrl
    import flash_pkg::*;
#(
    parameter int ADDR_W    = 11,
    parameter int SECT_W    = 5,
    parameter int PROG_CYC  = 8,
    parameter int PREP_CYC  = 4,
    parameter int ERASE_CYC = 40
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ce_n,
    input  logic                   we_n,
    input  logic                   oe_n,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [7:0]             wdata,
    output logic [7:0]             rdata,
    output logic                   ready,
    input  logic                   vlow,
    input  logic [(1<<SECT_W)-1:0] sect_prot
);
    localparam int BYTE_W   = ADDR_W - SECT_W;
    localparam int LAST_IDX = (1 << BYTE_W) - 1;
    localparam int PCW      = $clog2(PROG_CYC + 1);
    localparam int ECMAX    = (PREP_CYC > ERASE_CYC) ? PREP_CYC : ERASE_CYC;
    localparam int ECW      = $clog2(ECMAX + 1);

    op_state_e st, st_n, e_phase;

    logic              wr_evt, rd_evt;
    logic              go_prog, go_erase, go_susp, go_resume;
    logic              cmd_en, susp_en, busy;
    logic [ADDR_W-1:0] p_addr;
    logic [7:0]        p_data;
    logic [PCW-1:0]    p_cnt;
    logic [SECT_W-1:0] e_sect;
    logic [BYTE_W-1:0] e_idx;
    logic [ECW-1:0]    e_cnt;
    logic [ADDR_W-1:0] e_addr, b_addr, mem_waddr;
    logic [7:0]        h_rd, b_rd, mem_wdata, rd_val;
    logic              mem_we, tog;
    logic              p_last, byte_done, e_end, idx_last;
    logic [SECT_W-1:0] h_sect;
    logic              h_prot;

    assign h_sect    = addr[ADDR_W-1 -: SECT_W];
    assign h_prot    = sect_prot[h_sect];
    assign e_addr    = {e_sect, e_idx};
    assign p_last    = (p_cnt == PCW'(PROG_CYC - 1));
    assign byte_done = (b_rd == 8'h00) || (e_cnt == ECW'(PREP_CYC - 1));
    assign e_end     = (e_cnt == ECW'(ERASE_CYC - 1));
    assign idx_last  = (e_idx == BYTE_W'(LAST_IDX));
    assign cmd_en    = (st == OP_READ) || (st == OP_SUSP);
    assign susp_en   = (st == OP_PREP) || (st == OP_ERASE) || (st == OP_CLEAR);

    flash_bus_sync u_bus (
        .clk    (clk),
        .rst_n  (rst_n),
        .ce_n   (ce_n),
        .we_n   (we_n),
        .oe_n   (oe_n),
        .vlow   (vlow),
        .wr_evt (wr_evt),
        .rd_evt (rd_evt)
    );

    flash_cmd_decode #(.ADDR_W(ADDR_W)) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_evt    (wr_evt),
        .cmd_en    (cmd_en),
        .susp_en   (susp_en),
        .addr      (addr),
        .data      (wdata),
        .go_prog   (go_prog),
        .go_erase  (go_erase),
        .go_susp   (go_susp),
        .go_resume (go_resume)
    );

    flash_cell_array #(.ADDR_W(ADDR_W)) u_cells (
        .clk       (clk),
        .host_addr (addr),
        .host_q    (h_rd),
        .op_addr   (b_addr),
        .op_q      (b_rd),
        .we        (mem_we),
        .waddr     (mem_waddr),
        .wdata     (mem_wdata)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= OP_READ;
        else        st <= st_n;
    end

    // next state
    always_comb begin
        st_n = st;
        unique case (st)
            OP_READ: begin
                if (go_prog && !h_prot)       st_n = OP_PROG;
                else if (go_erase && !h_prot) st_n = OP_PREP;
            end
            OP_PROG:  if (p_last) st_n = OP_READ;
            OP_SPROG: if (p_last) st_n = OP_SUSP;
            OP_PREP: begin
                if (go_susp)                    st_n = OP_SUSP;
                else if (byte_done && idx_last) st_n = OP_ERASE;
            end
            OP_ERASE: begin
                if (go_susp)    st_n = OP_SUSP;
                else if (e_end) st_n = OP_CLEAR;
            end
            OP_CLEAR: begin
                if (go_susp)       st_n = OP_SUSP;
                else if (idx_last) st_n = OP_READ;
            end
            OP_SUSP: begin
                if (go_resume) st_n = e_phase;
                else if (go_prog && !h_prot && h_sect != e_sect) st_n = OP_SPROG;
            end
            default: st_n = OP_READ;
        endcase
    end

    // operation datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_addr  <= '0;
            p_data  <= '0;
            p_cnt   <= '0;
            e_sect  <= '0;
            e_idx   <= '0;
            e_cnt   <= '0;
            e_phase <= OP_PREP;
        end else begin
            if (go_prog && cmd_en) begin
                p_addr <= addr;
                p_data <= wdata;
                p_cnt  <= '0;
            end
            unique case (st)
                OP_READ: begin
                    if (go_erase) begin
                        e_sect <= h_sect;
                        e_idx  <= '0;
                        e_cnt  <= '0;
                    end
                end
                OP_PROG, OP_SPROG: p_cnt <= p_cnt + 1'b1;
                OP_PREP: begin
                    if (go_susp) e_phase <= OP_PREP;
                    else if (byte_done) begin
                        e_cnt <= '0;
                        e_idx <= e_idx + 1'b1;
                    end else begin
                        e_cnt <= e_cnt + 1'b1;
                    end
                end
                OP_ERASE: begin
                    if (go_susp)    e_phase <= OP_ERASE;
                    else if (e_end) e_cnt <= '0;
                    else            e_cnt <= e_cnt + 1'b1;
                end
                OP_CLEAR: begin
                    if (go_susp) e_phase <= OP_CLEAR;
                    else         e_idx <= e_idx + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // outputs: array write port, ready, read mux
    always_comb begin
        busy      = (st == OP_PROG) || (st == OP_SPROG) || susp_en;
        ready     = !busy;
        b_addr    = susp_en ? e_addr : p_addr;
        mem_we    = 1'b0;
        mem_waddr = b_addr;
        mem_wdata = b_rd & p_data;
        rd_val    = h_rd;
        unique case (st)
            OP_PROG, OP_SPROG: begin
                mem_we = p_last;
                rd_val = status_byte(~p_data[7], tog);
            end
            OP_PREP: begin
                mem_we    = !go_susp && (b_rd != 8'h00) && (e_cnt == ECW'(PREP_CYC - 1));
                mem_wdata = 8'h00;
                rd_val    = status_byte(1'b0, tog);
            end
            OP_ERASE: rd_val = status_byte(1'b0, tog);
            OP_CLEAR: begin
                mem_we    = !go_susp;
                mem_wdata = 8'hFF;
                rd_val    = status_byte(1'b0, tog);
            end
            OP_SUSP: if (h_sect == e_sect) rd_val = status_byte(1'b1, tog);
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= 8'h00;
            tog   <= 1'b0;
        end else if (rd_evt) begin
            rdata <= rd_val;
            if (busy) tog <= ~tog;
        end
    end

    AST_PROG_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (st == OP_PROG) |=> (st == OP_PROG || st == OP_READ)); // R2

    AST_PROT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (st == OP_PREP) |-> !sect_prot[e_sect]); // R10

    AST_VLOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (vlow && st == OP_READ) |=> (st == OP_READ)); // R11

    AST_SUSP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (st == OP_SUSP) |=> ($stable(e_idx) && $stable(e_cnt))); // R7

    AST_SPROG_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
        (st == OP_SPROG) |-> (p_addr[ADDR_W-1 -: SECT_W] != e_sect)); // R8

endmodule

// File: tb/tb_flash_op_ctrl.sv
`timescale 1ns/1ps
module tb_flash_op_ctrl;
    localparam int AW = 11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        ready;
    logic        vlow = 1'b0;
    logic [31:0] sect_prot = '0;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    flash_op_ctrl dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .wdata(wdata), .rdata(rdata), .ready(ready),
        .vlow(vlow), .sect_prot(sect_prot)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bwr(input int a, input int d);
        @(negedge clk);
        addr = AW'(a); wdata = 8'(d); ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1;
    endtask

    task automatic brd(input int a, output logic [7:0] d);
        @(negedge clk);
        addr = AW'(a); ce_n = 1'b0; oe_n = 1'b0;
        @(negedge clk);
        d = rdata; oe_n = 1'b1; ce_n = 1'b1;
    endtask

    task automatic prog_cmd(input int a, input int d);
        bwr(12'h555, 8'hAA); bwr(12'h2AA, 8'h55); bwr(12'h555, 8'hA0); bwr(a, d);
    endtask

    task automatic erase_cmd(input int s);
        bwr(12'h555, 8'hAA); bwr(12'h2AA, 8'h55); bwr(12'h555, 8'h80);
        bwr(12'h555, 8'hAA); bwr(12'h2AA, 8'h55); bwr(s * 64, 8'h30);
    endtask

    task automatic wait_rdy(output int n);
        n = 0;
        while (!ready && n < 20000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R1 ready after reset", int'(ready), 1);
        brd(12'h040, d);
        chk("R1 erased power-up byte", int'(d), 8'hFF);
    endtask

    task automatic t_program();
        logic [7:0] d1, d2;
        int n;
        prog_cmd(12'h041, 8'hF0);
        chk("R2 ready low after data write", int'(ready), 0);
        brd(12'h041, d1);
        brd(12'h041, d2);
        chk("R3 polling bit7 inverted", int'(d1[7]), 0);
        chk("R4 status low bits zero", int'(d1[5:0]), 0);
        chk("R4 toggle bit flips", int'(d1[6] ^ d2[6]), 1);
        wait_rdy(n);
        brd(12'h041, d1);
        chk("R3 true data after program", int'(d1), 8'hF0);
        prog_cmd(12'h042, 8'h3C);
        wait_rdy(n);
        chk("R2 program busy length", n, 8);
        prog_cmd(12'h041, 8'h3C);
        wait_rdy(n);
        brd(12'h041, d1);
        chk("R2 program only clears bits", int'(d1), 8'h30);
    endtask

    task automatic t_badseq();
        logic [7:0] d;
        int n;
        bwr(12'h555, 8'hAA); bwr(12'h2AA, 8'h56); bwr(12'h555, 8'hA0); bwr(12'h043, 8'h12);
        chk("R12 broken sequence no busy", int'(ready), 1);
        repeat (10) @(negedge clk);
        brd(12'h043, d);
        chk("R12 broken sequence no write", int'(d), 8'hFF);
        prog_cmd(12'h043, 8'h12);
        wait_rdy(n);
        brd(12'h043, d);
        chk("R12 fresh sequence works", int'(d), 8'h12);
    endtask

    task automatic t_vlow();
        logic [7:0] d;
        vlow = 1'b1;
        prog_cmd(12'h044, 8'h00);
        chk("R11 no busy under low supply", int'(ready), 1);
        repeat (12) @(negedge clk);
        vlow = 1'b0;
        brd(12'h044, d);
        chk("R11 byte unchanged", int'(d), 8'hFF);
    endtask

    task automatic t_protect();
        logic [7:0] d;
        sect_prot[3] = 1'b1;
        prog_cmd(3 * 64 + 1, 8'h00);
        chk("R10 protected program no busy", int'(ready), 1);
        repeat (10) @(negedge clk);
        brd(3 * 64 + 1, d);
        chk("R10 protected byte unchanged", int'(d), 8'hFF);
        erase_cmd(3);
        chk("R10 protected erase no busy", int'(ready), 1);
        sect_prot[3] = 1'b0;
    endtask

    task automatic t_erase();
        logic [7:0] d;
        int n;
        erase_cmd(7);
        wait_rdy(n);
        chk("R6 erase of blank sector cycles", n, 360);
        prog_cmd(5 * 64 + 9, 8'h00);
        wait_rdy(n);
        erase_cmd(5);
        wait_rdy(n);
        chk("R6 erase with one programmed byte", n, 357);
        brd(5 * 64 + 9, d);
        chk("R5 erased byte reads FF", int'(d), 8'hFF);
        prog_cmd(6 * 64 + 2, 8'h55);
        wait_rdy(n);
        erase_cmd(6);
        brd(6 * 64 + 2, d);
        chk("R5 erase polling bit7 zero", int'(d[7]), 0);
        chk("R4 erase status low bits", int'(d[5:0]), 0);
        wait_rdy(n);
        brd(6 * 64 + 2, d);
        chk("R5 sector erased", int'(d), 8'hFF);
        brd(12'h041, d);
        chk("R5 other sector untouched", int'(d), 8'h30);
    endtask

    task automatic t_suspend();
        logic [7:0] d1, d2;
        int n;
        prog_cmd(8 * 64 + 4, 8'h0F);
        wait_rdy(n);
        erase_cmd(8);
        repeat (20) @(negedge clk);
        bwr(0, 8'hB0);
        chk("R7 ready high when suspended", int'(ready), 1);
        brd(12'h041, d1);
        chk("R7 other sector readable", int'(d1), 8'h30);
        brd(8 * 64 + 4, d1);
        brd(8 * 64 + 4, d2);
        chk("R7 erasing sector bit7 one", int'(d1[7]), 1);
        chk("R7 erasing sector bit6 still", int'(d1[6] ^ d2[6]), 0);
        prog_cmd(9 * 64 + 1, 8'h81);
        chk("R8 program in suspend busy", int'(ready), 0);
        wait_rdy(n);
        chk("R8 suspended program length", n, 8);
        chk("R8 back to suspended ready", int'(ready), 1);
        brd(9 * 64 + 1, d1);
        chk("R8 suspended program data", int'(d1), 8'h81);
        prog_cmd(8 * 64 + 5, 8'h00);
        chk("R8 program to erasing sector ignored", int'(ready), 1);
        bwr(0, 8'h30);
        chk("R9 resume goes busy", int'(ready), 0);
        wait_rdy(n);
        brd(8 * 64 + 4, d1);
        chk("R9 erase completes after resume", int'(d1), 8'hFF);
        brd(8 * 64 + 5, d1);
        chk("R9 ignored byte erased", int'(d1), 8'hFF);
        brd(9 * 64 + 1, d1);
        chk("R8 suspended program kept", int'(d1), 8'h81);
    endtask

    task automatic t_hwreset();
        logic [7:0] d;
        int n;
        prog_cmd(12 * 64, 8'h00);
        chk("R1 program running before reset", int'(ready), 0);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready after abort", int'(ready), 1);
        brd(12 * 64, d);
        chk("R1 aborted byte unchanged", int'(d), 8'hFF);
        erase_cmd(13);
        repeat (10) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 erase aborted", int'(ready), 1);
        prog_cmd(12 * 64, 8'h5A);
        wait_rdy(n);
        brd(12 * 64, d);
        chk("R1 command works after reset", int'(d), 8'h5A);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_program();
        t_badseq();
        t_vlow();
        t_protect();
        t_erase();
        t_suspend();
        t_hwreset();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule